// File: doc/BRIEF.md
# PLL Power Sequencer

This block drives the three control lines of an external PLL macro: bypass release, an active-low reset, and the output gate. It switches them in a safe order and holds each step for a minimum time. A single-cycle enable or disable command starts a sequence. All waits are counted in microseconds, and a reference-cycle parameter converts them into clock cycles. While the block waits for the PLL to report lock, a limit on that wait stops a dead PLL from hanging the caller. When that limit expires, the block raises an error flag that stays set.

A second mode replaces the manual bring-up with a vote. On enable, the block only raises a vote output and waits for an active flag from whatever arbitrates the PLL. On disable, it only withdraws the vote. The status outputs are the same in both modes: busy for the length of a sequence, a done pulse at the end, and the sticky timeout flag.

Top module: `pll_pwr_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, bypassRel, pllResetN, outEn, voteEn, busy, done and timeoutErr are all 0.
- R2: A manual enable sets bypassRel first, then pllResetN, and sets outEn only after lockDet has been seen high. The sequence ends with all three controls at 1.
- R3: pllResetN rises exactly RELEASE_US*CYCLES_PER_US+1 cycles after bypassRel rises (21 cycles with the defaults).
- R4: While waiting for lockDet (manual mode) or activeFlag (vote mode), if the input is not seen within POLL_LIMIT_US microseconds, the block sets timeoutErr, drops busy without a done pulse, and leaves every control output at its current value. In manual mode this comes POLL_LIMIT_US*CYCLES_PER_US+1 cycles after pllResetN rises.
- R5: If bypassRel, pllResetN and outEn are all 1 when a manual enable is accepted, no control output changes, busy stays 0, and done pulses on the next cycle.
- R6: A manual disable clears outEn first. bypassRel and pllResetN then fall together on the same cycle, SETTLE_US*CYCLES_PER_US+1 cycles later.
- R7: A vote-mode enable sets voteEn and waits for activeFlag, leaving bypassRel, pllResetN and outEn unchanged. Done pulses on the cycle after activeFlag is seen.
- R8: A vote-mode disable clears voteEn and pulses done on the next cycle, without entering a busy state.
- R9: startEn and startDis are ignored while busy is 1.
- R10: timeoutErr stays 1 until the next accepted command, which clears it on the following cycle.
- R11: busy is 1 from the cycle after a sequence is accepted until it completes. done is a one-cycle pulse, and busy is 0 whenever done is 1.
- R12: If startEn and startDis are both 1 in the same idle cycle, the enable is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startEn | input | 1 | Enable command, sampled when idle |
| startDis | input | 1 | Disable command, sampled when idle |
| voteMode | input | 1 | 1 selects the vote path, 0 the manual sequence |
| lockDet | input | 1 | Lock indication from the PLL |
| activeFlag | input | 1 | Active indication from the vote arbiter |
| bypassRel | output | 1 | Bypass-release control to the PLL |
| pllResetN | output | 1 | Active-low reset to the PLL |
| outEn | output | 1 | Output gate of the PLL |
| voteEn | output | 1 | Enable vote |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| timeoutErr | output | 1 | Sticky wait-limit error |

## Verification
The assertions assume that voteMode changes only when no vote is held and no sequence is running. They also assume that lockDet is never treated as meaningful before pllResetN rises. The stimulus follows both rules: voteMode changes only between sequences, after a disable has dropped any vote, and lockDet stays 0 until pllResetN is seen high. The ordering and gap properties can then rely on the reset, bypass and gate lines being moved only by this block's own steps.

// File: rtl/pll_pwr_seq_pkg.sv
package pll_pwr_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_BYPASS_HOLD,
    S_LOCK_WAIT,
    S_DRAIN,
    S_VOTE_WAIT
  } seq_state_e;

  // Strobes from control to datapath; each one acts for a single cycle.
  typedef struct packed {
    logic clrTimer;
    logic setBypass;
    logic clrBypass;
    logic setRst;
    logic clrRst;
    logic setOut;
    logic clrOut;
    logic setVote;
    logic clrVote;
    logic setErr;
    logic clrErr;
    logic pulseDone;
  } seq_strobe_t;

endpackage

// File: rtl/pll_pwr_seq_dp.sv
module pll_pwr_seq_dp
  import pll_pwr_seq_pkg::*;
#(
  parameter int CYCLES_PER_US = 4,
  parameter int MAX_US        = 100,
  parameter int US_W          = 7
) (
  input  logic        clk,
  input  logic        rstN,
  input  seq_strobe_t strobe,
  output logic [US_W-1:0] usCount,
  output logic        bypassRel,
  output logic        pllResetN,
  output logic        outEn,
  output logic        voteEn,
  output logic        done,
  output logic        timeoutErr
);

  localparam int PRE_W = $clog2(CYCLES_PER_US + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYCLES_PER_US - 1);
  localparam logic [US_W-1:0]  US_SAT   = US_W'(MAX_US);

  logic [PRE_W-1:0] preCount;

  // Microsecond timebase, restarted at the start of every step
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCount <= '0;
      usCount  <= '0;
    end else if (strobe.clrTimer) begin
      preCount <= '0;
      usCount  <= '0;
    end else if (preCount == PRE_LAST) begin
      preCount <= '0;
      if (usCount != US_SAT) usCount <= usCount + 1'b1;
    end else begin
      preCount <= preCount + 1'b1;
    end
  end

  // Control and status registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bypassRel  <= 1'b0;
      pllResetN  <= 1'b0;
      outEn      <= 1'b0;
      voteEn     <= 1'b0;
      done       <= 1'b0;
      timeoutErr <= 1'b0;
    end else begin
      done <= strobe.pulseDone;
      if (strobe.setBypass)      bypassRel <= 1'b1;
      else if (strobe.clrBypass) bypassRel <= 1'b0;
      if (strobe.setRst)         pllResetN <= 1'b1;
      else if (strobe.clrRst)    pllResetN <= 1'b0;
      if (strobe.setOut)         outEn <= 1'b1;
      else if (strobe.clrOut)    outEn <= 1'b0;
      if (strobe.setVote)        voteEn <= 1'b1;
      else if (strobe.clrVote)   voteEn <= 1'b0;
      if (strobe.setErr)         timeoutErr <= 1'b1;
      else if (strobe.clrErr)    timeoutErr <= 1'b0;
    end
  end

endmodule

// File: rtl/pll_pwr_seq_ctrl.sv
module pll_pwr_seq_ctrl
  import pll_pwr_seq_pkg::*;
#(
  parameter int RELEASE_US    = 5,
  parameter int SETTLE_US     = 1,
  parameter int POLL_LIMIT_US = 100,
  parameter int US_W          = 7
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startEn,
  input  logic            startDis,
  input  logic            voteMode,
  input  logic            lockDet,
  input  logic            activeFlag,
  input  logic [US_W-1:0] usCount,
  input  logic            bypassRel,
  input  logic            pllResetN,
  input  logic            outEn,
  output seq_strobe_t     strobe,
  output logic            busy
);

  localparam logic [US_W-1:0] REL_US  = US_W'(RELEASE_US);
  localparam logic [US_W-1:0] SET_US  = US_W'(SETTLE_US);
  localparam logic [US_W-1:0] POLL_US = US_W'(POLL_LIMIT_US);

  seq_state_e state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  assign busy = (state != S_IDLE);

  always_comb begin
    nxt    = state;
    strobe = '0;
    case (state)
      S_IDLE: begin
        if (startEn) begin
          strobe.clrErr = 1'b1;
          if (voteMode) begin
            strobe.setVote  = 1'b1;
            strobe.clrTimer = 1'b1;
            nxt             = S_VOTE_WAIT;
          end else if (bypassRel && pllResetN && outEn) begin
            strobe.pulseDone = 1'b1;
          end else begin
            strobe.setBypass = 1'b1;
            strobe.clrTimer  = 1'b1;
            nxt              = S_BYPASS_HOLD;
          end
        end else if (startDis) begin
          strobe.clrErr = 1'b1;
          if (voteMode) begin
            strobe.clrVote   = 1'b1;
            strobe.pulseDone = 1'b1;
          end else begin
            strobe.clrOut   = 1'b1;
            strobe.clrTimer = 1'b1;
            nxt             = S_DRAIN;
          end
        end
      end
      S_BYPASS_HOLD: begin
        if (usCount >= REL_US) begin
          strobe.setRst   = 1'b1;
          strobe.clrTimer = 1'b1;
          nxt             = S_LOCK_WAIT;
        end
      end
      S_LOCK_WAIT: begin
        if (lockDet) begin
          strobe.setOut    = 1'b1;
          strobe.pulseDone = 1'b1;
          nxt              = S_IDLE;
        end else if (usCount >= POLL_US) begin
          strobe.setErr = 1'b1;
          nxt           = S_IDLE;
        end
      end
      S_DRAIN: begin
        if (usCount >= SET_US) begin
          strobe.clrRst    = 1'b1;
          strobe.clrBypass = 1'b1;
          strobe.pulseDone = 1'b1;
          nxt              = S_IDLE;
        end
      end
      S_VOTE_WAIT: begin
        if (activeFlag) begin
          strobe.pulseDone = 1'b1;
          nxt              = S_IDLE;
        end else if (usCount >= POLL_US) begin
          strobe.setErr = 1'b1;
          nxt           = S_IDLE;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

endmodule

// File: rtl/pll_pwr_seq.sv
module pll_pwr_seq
  import pll_pwr_seq_pkg::*;
#(
  parameter int CYCLES_PER_US = 4,
  parameter int RELEASE_US    = 5,
  parameter int SETTLE_US     = 1,
  parameter int POLL_LIMIT_US = 100
) (
  input  logic clk,
  input  logic rstN,
  input  logic startEn,
  input  logic startDis,
  input  logic voteMode,
  input  logic lockDet,
  input  logic activeFlag,
  output logic bypassRel,
  output logic pllResetN,
  output logic outEn,
  output logic voteEn,
  output logic busy,
  output logic done,
  output logic timeoutErr
);

  localparam int MAX_A  = (RELEASE_US > SETTLE_US) ? RELEASE_US : SETTLE_US;
  localparam int MAX_US = (MAX_A > POLL_LIMIT_US) ? MAX_A : POLL_LIMIT_US;
  localparam int US_W   = $clog2(MAX_US + 1);

  seq_strobe_t     strobe;
  logic [US_W-1:0] usCount;

  pll_pwr_seq_ctrl #(
    .RELEASE_US   (RELEASE_US),
    .SETTLE_US    (SETTLE_US),
    .POLL_LIMIT_US(POLL_LIMIT_US),
    .US_W         (US_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startEn   (startEn),
    .startDis  (startDis),
    .voteMode  (voteMode),
    .lockDet   (lockDet),
    .activeFlag(activeFlag),
    .usCount   (usCount),
    .bypassRel (bypassRel),
    .pllResetN (pllResetN),
    .outEn     (outEn),
    .strobe    (strobe),
    .busy      (busy)
  );

  pll_pwr_seq_dp #(
    .CYCLES_PER_US(CYCLES_PER_US),
    .MAX_US       (MAX_US),
    .US_W         (US_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .usCount   (usCount),
    .bypassRel (bypassRel),
    .pllResetN (pllResetN),
    .outEn     (outEn),
    .voteEn    (voteEn),
    .done      (done),
    .timeoutErr(timeoutErr)
  );

endmodule

// File: rtl/pll_pwr_seq_chk.sv
module pll_pwr_seq_chk #(
  parameter int CYCLES_PER_US = 4,
  parameter int RELEASE_US    = 5,
  parameter int POLL_LIMIT_US = 100
) (
  input logic clk,
  input logic rstN,
  input logic lockDet,
  input logic bypassRel,
  input logic pllResetN,
  input logic outEn,
  input logic voteEn,
  input logic busy,
  input logic done,
  input logic timeoutErr
);

  localparam int GAP_MIN   = RELEASE_US * CYCLES_PER_US;
  localparam int BUSY_MAX  = (RELEASE_US + POLL_LIMIT_US) * CYCLES_PER_US + 4;
  localparam int CNT_W     = $clog2(BUSY_MAX + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = {CNT_W{1'b1}};

  logic             prevBypass;
  logic [CNT_W-1:0] gapCnt;
  logic [CNT_W-1:0] busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevBypass <= 1'b0;
      gapCnt     <= '0;
      busyCnt    <= '0;
    end else begin
      prevBypass <= bypassRel;
      if (bypassRel && !prevBypass) gapCnt <= '0;
      else if (gapCnt != CNT_SAT)   gapCnt <= gapCnt + 1'b1;
      if (!busy)                    busyCnt <= '0;
      else if (busyCnt != CNT_SAT)  busyCnt <= busyCnt + 1'b1;
    end
  end

  // R2: the gate opens only with reset released, bypass on and lock seen
  p_gate_after_lock_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outEn) |-> (pllResetN && bypassRel && $past(lockDet)));

  // R2: reset is never released without bypass release
  p_rst_needs_bypass_r2: assert property (@(posedge clk) disable iff (!rstN)
    pllResetN |-> bypassRel);

  // R3: minimum gap between bypass release and reset release
  p_release_gap_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pllResetN) |-> (int'(gapCnt) >= GAP_MIN));

  // R4: no sequence stays busy beyond the longest bounded wait
  p_busy_bounded_r4: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (int'(busyCnt) <= BUSY_MAX));

  // R6: the gate is closed before reset and bypass drop, and those two drop together
  p_shutdown_order_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pllResetN) |-> (!outEn && $fell(bypassRel)));

  // R7: manual controls do not move while a vote is being waited on
  p_vote_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && voteEn) |=> $stable({bypassRel, pllResetN, outEn}));

  // R11: done pulses only while idle and lasts one cycle
  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R11: a sequence ends either with done or with the error flag
  p_busy_end_r11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (done || timeoutErr));

endmodule

bind pll_pwr_seq pll_pwr_seq_chk #(
  .CYCLES_PER_US(CYCLES_PER_US),
  .RELEASE_US   (RELEASE_US),
  .POLL_LIMIT_US(POLL_LIMIT_US)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .lockDet   (lockDet),
  .bypassRel (bypassRel),
  .pllResetN (pllResetN),
  .outEn     (outEn),
  .voteEn    (voteEn),
  .busy      (busy),
  .done      (done),
  .timeoutErr(timeoutErr)
);

// File: tb/test_pll_pwr_seq.sv
`timescale 1ns/1ps
module test_pll_pwr_seq;

  localparam int CPU  = 4;
  localparam int REL  = 5;
  localparam int SET  = 1;
  localparam int POLL = 100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startEn = 1'b0, startDis = 1'b0, voteMode = 1'b0;
  logic lockDet = 1'b0, activeFlag = 1'b0;
  logic bypassRel, pllResetN, outEn, voteEn, busy, done, timeoutErr;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #5 clk = ~clk;

  pll_pwr_seq #(
    .CYCLES_PER_US(CPU), .RELEASE_US(REL), .SETTLE_US(SET), .POLL_LIMIT_US(POLL)
  ) i_pll_pwr_seq (
    .clk(clk), .rstN(rstN), .startEn(startEn), .startDis(startDis),
    .voteMode(voteMode), .lockDet(lockDet), .activeFlag(activeFlag),
    .bypassRel(bypassRel), .pllResetN(pllResetN), .outEn(outEn),
    .voteEn(voteEn), .busy(busy), .done(done), .timeoutErr(timeoutErr)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // mode: 0 idle, 1 bypass hold, 2 lock wait, 3 drain, 4 vote wait
  int   mMode = 0;
  int   mElapsed = 0;
  logic mByp = 0, mRst = 0, mOut = 0, mVote = 0, mDone = 0, mErr = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMode <= 0; mElapsed <= 0;
      mByp <= 0; mRst <= 0; mOut <= 0; mVote <= 0; mDone <= 0; mErr <= 0;
    end else begin
      mDone <= 1'b0;
      case (mMode)
        0: if (startEn) begin
             mErr <= 1'b0;
             if (voteMode) begin mVote <= 1'b1; mMode <= 4; mElapsed <= 0; end
             else if (mByp && mRst && mOut) mDone <= 1'b1;
             else begin mByp <= 1'b1; mMode <= 1; mElapsed <= 0; end
           end else if (startDis) begin
             mErr <= 1'b0;
             if (voteMode) begin mVote <= 1'b0; mDone <= 1'b1; end
             else begin mOut <= 1'b0; mMode <= 3; mElapsed <= 0; end
           end
        1: if (mElapsed >= REL*CPU) begin mRst <= 1'b1; mMode <= 2; mElapsed <= 0; end
           else mElapsed <= mElapsed + 1;
        2: if (lockDet) begin mOut <= 1'b1; mDone <= 1'b1; mMode <= 0; end
           else if (mElapsed >= POLL*CPU) begin mErr <= 1'b1; mMode <= 0; end
           else mElapsed <= mElapsed + 1;
        3: if (mElapsed >= SET*CPU) begin mByp <= 1'b0; mRst <= 1'b0; mDone <= 1'b1; mMode <= 0; end
           else mElapsed <= mElapsed + 1;
        4: if (activeFlag) begin mDone <= 1'b1; mMode <= 0; end
           else if (mElapsed >= POLL*CPU) begin mErr <= 1'b1; mMode <= 0; end
           else mElapsed <= mElapsed + 1;
        default: mMode <= 0;
      endcase
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      chk("R2",  "bypassRel",  int'(bypassRel),  int'(mByp));
      chk("R2",  "pllResetN",  int'(pllResetN),  int'(mRst));
      chk("R2",  "outEn",      int'(outEn),      int'(mOut));
      chk("R7",  "voteEn",     int'(voteEn),     int'(mVote));
      chk("R11", "busy",       int'(busy),       int'(mMode != 0));
      chk("R11", "done",       int'(done),       int'(mDone));
      chk("R10", "timeoutErr", int'(timeoutErr), int'(mErr));
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 60000) begin
      nChecks++;
      nFails++;
      $display("FAIL R11 watchdog actual=%0d expected<=60000 cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  task automatic pulseCmd(input logic en, input logic dis);
    @(negedge clk);
    startEn = en; startDis = dis;
    @(negedge clk);
    startEn = 1'b0; startDis = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
  endtask

  initial begin
    int gap;
    repeat (3) @(negedge clk);
    chk("R1", "outputs in reset", int'({bypassRel, pllResetN, outEn, voteEn, busy, done, timeoutErr}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "outputs after reset", int'({bypassRel, pllResetN, outEn, voteEn, busy, done, timeoutErr}), 0);

    // R12 + R3 + R2: both commands together, enable taken
    pulseCmd(1'b1, 1'b1);
    chk("R12", "bypassRel on joint command", int'(bypassRel), 1);
    chk("R12", "busy on joint command", int'(busy), 1);
    chk("R2", "reset still held first", int'(pllResetN), 0);
    gap = 0;
    for (int i = 0; i < 200 && !pllResetN; i++) begin @(negedge clk); gap++; end
    chk("R3", "bypass to reset gap", gap, REL*CPU + 1);
    chk("R2", "gate closed before lock", int'(outEn), 0);
    repeat (7) @(negedge clk);
    chk("R2", "gate still closed without lock", int'(outEn), 0);
    lockDet = 1'b1;
    waitIdle();
    chk("R2", "controls on after lock", int'({bypassRel, pllResetN, outEn}), 7);

    // R5: enable when already on
    pulseCmd(1'b1, 1'b0);
    chk("R5", "done at once", int'(done), 1);
    chk("R5", "no busy", int'(busy), 0);
    chk("R5", "controls untouched", int'({bypassRel, pllResetN, outEn}), 7);

    // R6 + R9: disable, with an enable attempted while draining
    pulseCmd(1'b0, 1'b1);
    chk("R6", "gate closes first", int'({bypassRel, pllResetN, outEn}), 6);
    startEn = 1'b1;
    @(negedge clk);
    startEn = 1'b0;
    gap = 1;
    for (int i = 0; i < 50 && pllResetN; i++) begin @(negedge clk); gap++; end
    chk("R6", "drain length", gap, SET*CPU + 1);
    chk("R6", "bypass drops with reset", int'(bypassRel), 0);
    lockDet = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9", "enable during drain ignored", int'({bypassRel, pllResetN, outEn, busy}), 0);

    // R4: manual lock wait times out
    pulseCmd(1'b1, 1'b0);
    for (int i = 0; i < 200 && !pllResetN; i++) @(negedge clk);
    gap = 0;
    for (int i = 0; i < 1000 && busy; i++) begin @(negedge clk); gap++; end
    chk("R4", "lock wait length", gap, POLL*CPU + 1);
    chk("R4", "error set", int'(timeoutErr), 1);
    chk("R4", "controls held", int'({bypassRel, pllResetN, outEn}), 6);
    chk("R4", "no done on timeout", int'(done), 0);
    repeat (5) @(negedge clk);
    chk("R10", "error sticky", int'(timeoutErr), 1);

    // R10: accepted disable clears the error
    pulseCmd(1'b0, 1'b1);
    chk("R10", "error cleared", int'(timeoutErr), 0);
    waitIdle();
    repeat (2) @(negedge clk);

    // R7 / R8: vote path
    voteMode = 1'b1;
    pulseCmd(1'b1, 1'b0);
    chk("R7", "vote raised", int'(voteEn), 1);
    chk("R7", "busy while voting", int'(busy), 1);
    repeat (9) @(negedge clk);
    chk("R7", "manual controls untouched", int'({bypassRel, pllResetN, outEn}), 0);
    activeFlag = 1'b1;
    @(negedge clk);
    chk("R7", "done after active", int'(done), 1);
    chk("R7", "vote held", int'(voteEn), 1);
    pulseCmd(1'b0, 1'b1);
    chk("R8", "vote dropped", int'(voteEn), 0);
    chk("R8", "done on unvote", int'(done), 1);
    chk("R8", "no busy on unvote", int'(busy), 0);
    activeFlag = 1'b0;

    // R4 in vote mode
    pulseCmd(1'b1, 1'b0);
    waitIdle();
    chk("R4", "vote timeout error", int'(timeoutErr), 1);
    chk("R4", "vote held after timeout", int'(voteEn), 1);
    pulseCmd(1'b0, 1'b1);
    chk("R10", "error cleared by unvote", int'(timeoutErr), 0);
    voteMode = 1'b0;
    repeat (4) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule